// File: doc/BRIEF.md
# Four-Function Byte ALU

This block is a purely combinational arithmetic logic unit for two byte-wide operands. A two-bit operation code picks one of four results: the sum, the difference, the bitwise OR or the bitwise AND of the operands. The chosen result drives the result bus. A carry flag comes out alongside it.

Addition and subtraction share one ripple chain of full adders. For subtraction, each bit of the second operand passes through an inverter, and the chain's carry input is tied high. The first carry into the chain therefore turns the inverted operand into its two's complement, and no separate subtractor is needed.

The block holds no state. A new operand pair or operation code shows at the outputs as soon as the logic has settled, with no clock involved.

Top module: `alu4_core`

## Requirements
- R1: With `op_sel` = 2'b00, `res` equals (`opa` + `opb`) mod 256, and `carry_out` equals bit 8 of the 9-bit sum.
- R2: With `op_sel` = 2'b10, `res` equals (`opa` - `opb`) mod 256, and `carry_out` is 1 exactly when `opa` >= `opb` as unsigned values (1 means no borrow).
- R3: With `op_sel` = 2'b01, `res` equals `opa` | `opb`.
- R4: With `op_sel` = 2'b11, `res` equals `opa` & `opb`.
- R5: For the two bitwise codes (2'b01 and 2'b11), `carry_out` is 0 whatever the operands.
- R6: Adding 0xFF and 0x01 gives `res` = 0x00 with `carry_out` = 1.
- R7: Subtracting 0x05 from 0x03 gives `res` = 0xFE with `carry_out` = 0.
- R8: The outputs follow any change on the operands or the operation code with no clock edge between the change and the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand (minuend for subtraction) |
| opb | input | 8 | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | Operation code: 00 add, 01 OR, 10 subtract, 11 AND |
| res | output | 8 | Result of the selected operation |
| carry_out | output | 1 | Adder carry for add and subtract; 0 for bitwise codes |

## Verification
The embedded checks are immediate assertions evaluated whenever the combinational logic settles. They assume that `opa`, `opb` and `op_sel` always carry known 0/1 values, because an unknown bit would make the arithmetic identities meaningless. The stimulus only ever drives fully defined values. It changes them half a period away from the bench clock's rising edge and samples the outputs a fixed delay later, so every comparison sees settled logic.

// File: rtl/alu4_pkg.sv
// Package: shared operation encoding for the byte ALU.
// Assumes the operation code is two bits wide and fully decoded.
package alu4_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_OR  = 2'b01,
        OP_SUB = 2'b10,
        OP_AND = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu4_full_add.sv
// One-bit full adder cell, used as the unit of the ripple chain.
// Assumes nothing beyond known input levels.
module alu4_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and carry of one bit position.
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/alu4_ripple.sv
// Ripple-carry adder and subtractor of W bits. When invert_b is high, each
// bit of b is inverted and the chain carry input is 1, which gives a - b.
// Assumes known input levels; carry_out is the chain's top carry.
module alu4_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    // Conditional inversion of b and carry seed.
    always_comb begin
        b_eff    = b ^ {W{invert_b}};
        chain[0] = invert_b;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        alu4_full_add u_fa (
            .x  (a[i]),
            .y  (b_eff[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign carry_out = chain[W];

    // Chain result must match a whole-word addition (R1, R2).
    always_comb begin
        p_chain_sum_r1: assert ({carry_out, sum} ==
            ({1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, invert_b}));
    end
endmodule

// File: rtl/alu4_bitwise.sv
// Bitwise AND and OR of two W-bit operands.
// Assumes known input levels.
module alu4_bitwise #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit gates.
        assign and_o[i] = a[i] & b[i];
        assign or_o[i]  = a[i] | b[i];
    end

    // An AND bit can never be set where the OR bit is clear (R4).
    always_comb begin
        p_and_within_or_r4: assert ((and_o & ~or_o) == '0);
    end
endmodule

// File: rtl/alu4_core.sv
// Top of the byte ALU: decodes the operation code, runs the shared ripple
// chain for add/subtract and the bitwise unit, and steers one result out.
// Assumes op_sel, opa and opb always carry known levels. Holds no state.
module alu4_core
    import alu4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] res,
    output logic         carry_out
);
    alu_op_e      op;
    logic         do_sub;
    logic [W-1:0] arith_sum;
    logic         arith_carry;
    logic [W-1:0] and_val;
    logic [W-1:0] or_val;

    // Operation decode.
    always_comb begin
        op     = alu_op_e'(op_sel);
        do_sub = (op == OP_SUB);
    end

    alu4_ripple #(.W(W)) u_chain (
        .a         (opa),
        .b         (opb),
        .invert_b  (do_sub),
        .sum       (arith_sum),
        .carry_out (arith_carry)
    );

    alu4_bitwise #(.W(W)) u_logic (
        .a     (opa),
        .b     (opb),
        .and_o (and_val),
        .or_o  (or_val)
    );

    // Result steering and carry gating.
    always_comb begin
        case (op)
            OP_OR:   begin res = or_val;    carry_out = 1'b0;        end
            OP_AND:  begin res = and_val;   carry_out = 1'b0;        end
            default: begin res = arith_sum; carry_out = arith_carry; end
        endcase
    end

    // Port-level identities for each operation (R2, R3, R4, R5).
    always_comb begin
        if (op == OP_AND) begin
            p_and_subset_r4: assert ((res & ~opa) == '0);
        end
        if (op == OP_OR) begin
            p_or_superset_r3: assert ((opa & ~res) == '0);
        end
        if (op == OP_SUB) begin
            p_sub_inverse_r2: assert (W'(res + opb) == opa);
        end
        if (op == OP_AND || op == OP_OR) begin
            p_no_logic_carry_r5: assert (!carry_out);
        end
    end
endmodule

// File: tb/tb_alu4_core.sv
// Directed and random bench for alu4_core; one task per scenario.
module tb_alu4_core;
    logic       clk = 1'b0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] res;
    logic       carry_out;
    int checks = 0;
    int errors = 0;

    alu4_core dut (
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .res       (res),
        .carry_out (carry_out)
    );

    // 125 MHz pacing clock.
    always #4 clk = ~clk;

    // Independent reference model of the four operations.
    function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [1:0] s);
        case (s)
            2'b00:   return {1'b0, a} + {1'b0, b};
            2'b01:   return {1'b0, a | b};
            2'b10:   return {(a >= b), 8'(a - b)};
            default: return {1'b0, a & b};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R3/R5";
            2'b10:   return "R2";
            default: return "R4/R5";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [8:0] exp);
        checks++;
        if ({carry_out, res} !== exp) begin
            errors++;
            $display("FAIL %s a=%02h b=%02h sel=%b got c=%b z=%02h exp c=%b z=%02h",
                     tag, opa, opb, op_sel, carry_out, res, exp[8], exp[7:0]);
        end
    endtask

    // Drive at the falling edge, sample 2 ns later.
    task automatic apply(input logic [7:0] a, input logic [7:0] b,
                         input logic [1:0] s, input string tag);
        @(negedge clk);
        opa = a; opb = b; op_sel = s;
        #2;
        compare(tag, model(a, b, s));
    endtask

    task automatic t_idle;
        apply(8'h00, 8'h00, 2'b00, "R1 idle zeros");
    endtask

    task automatic t_corners;
        logic [7:0] pat [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(pat[i], pat[j], 2'(s), req_of(2'(s)));
    endtask

    task automatic t_add_wrap;
        apply(8'hFF, 8'h01, 2'b00, "R6 255+1");
        compare("R6 explicit", 9'h100);
    endtask

    task automatic t_sub_negative;
        apply(8'h03, 8'h05, 2'b10, "R7 3-5");
        compare("R7 explicit", 9'h0FE);
        apply(8'h05, 8'h03, 2'b10, "R2 5-3 no borrow");
        apply(8'h42, 8'h42, 2'b10, "R2 equal operands");
    endtask

    task automatic t_logic_carry;
        apply(8'hFF, 8'hFF, 2'b11, "R5 AND carry low");
        apply(8'hFF, 8'hFF, 2'b01, "R5 OR carry low");
        apply(8'hFF, 8'h00, 2'b01, "R3 all ones");
        apply(8'hFF, 8'h00, 2'b11, "R4 all zeros");
    endtask

    // Change inputs mid-cycle, no clock edge in between.
    task automatic t_comb_follow;
        @(posedge clk);
        #1;
        opa = 8'h10; opb = 8'h20; op_sel = 2'b00;
        #1;
        compare("R8 follow operands", 9'h030);
        op_sel = 2'b10;
        #1;
        compare("R8 follow select", 9'h0F0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 1000; n++)
            for (int s = 0; s < 4; s++)
                apply(8'($urandom), 8'($urandom), 2'(s), req_of(2'(s)));
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_idle();
        t_corners();
        t_add_wrap();
        t_sub_negative();
        t_logic_carry();
        t_comb_follow();
        t_random();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule